// File: doc/BRIEF.md
# Stereo z0 Line Fitter

This block completes a track fit in the non-bending plane. For every seed it receives the angles measured on six stereo layers, the angle and curvature corrections found by the earlier bending-plane fit, and the refined curvature from that fit. It corrects each stereo angle, scales it into a z position with a per-layer radius factor, and builds two weighted sums over the layers that recorded a hit. It then solves a straight-line fit in closed form to give the z intercept (z0) and the dip slope. All weights and denominators come from loadable coefficient tables, so the datapath only adds, multiplies and shifts.

A curvature-binning table turns the refined curvature into a small bin number. That bin, together with the six-bit stereo hit pattern, selects the precomputed weight sums, the denominator and the z0 error. The pipeline accepts one seed per clock. Results come out in arrival order a fixed number of cycles later, and the full 10-bit hit map travels alongside them unchanged. The tables are written through a simple select/address/data port before seeds are sent.

Top module: `stereo_zfit`

## Requirements
- R1: A seed presented with `seed_vld` high at a rising edge yields `z0_vld`, `dip_vld` and `z0err_vld` high exactly 7 clock cycles later. One seed may enter every cycle, and results leave in arrival order.
- R2: `hit_out` equals the full 10-bit `seed_hit` of the seed whose results are being presented.
- R3: Only bits 0 to 5 of the hit map take part in the fit (bit i marks stereo layer i). Bits 6 to 9 have no effect on z0, dip or z0 error.
- R4: The curvature bin is the bin table entry addressed by `seed_rho`, read as an 8-bit unsigned address.
- R5: The corrected angle of layer i is phi_i − dphi + ((slope[i·8+bin] · drho) >>> 6), where slope is the per-layer, per-bin table.
- R6: The z of layer i is (radius[i] · corrected angle) >>> 8.
- R7: S1 is the sum of z_i · w0[i] and S2 is the sum of z_i · w1[i·8+bin], both taken over the layers whose hit bit is set. With no stereo bit set, z0 and dip are 0.
- R8: With k = hit[5:0]·8 + bin, z0 = ((((S1·T1[k]) >>> 6) − ((S2·T2[k]) >>> 6)) · D[k]) >>> 16, truncated to 16-bit two's complement.
- R9: dip = ((((S2·T3[hit[5:0]]) >>> 1) − ((S1·T2[k]) >>> 1)) · D[k]) >>> 16, truncated to 16-bit two's complement.
- R10: The z0 error is the error table entry at address k.
- R11: Writing with `cfg_we` high stores `cfg_data` (its low bits, as wide as the entry) at `cfg_addr` in the table chosen by `cfg_sel`: 0 bin, 1 slope, 2 radius, 3 w0, 4 w1, 5 T1, 6 T2, 7 T3, 8 D, 9 error. Later seeds use the new value.
- R12: After reset all outputs are 0. Between valid strobes, z0, dip, z0 error and hit map keep their last presented values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_vld | input | 1 | Seed data valid |
| seed_hit | input | 10 | Hit map; low six bits mark stereo layers |
| seed_phi | input | 72 | Six 12-bit signed stereo angles, layer i at bits 12i+11..12i |
| seed_dphi | input | 12 | Signed angle correction |
| seed_drho | input | 12 | Signed curvature correction |
| seed_rho | input | 8 | Refined curvature (bin table address) |
| cfg_we | input | 1 | Table write enable |
| cfg_sel | input | 4 | Table select code |
| cfg_addr | input | 9 | Table entry address |
| cfg_data | input | 16 | Table entry data |
| z0_vld | output | 1 | z0 valid strobe |
| z0_out | output | 16 | Signed z intercept |
| dip_vld | output | 1 | Dip valid strobe |
| dip_out | output | 16 | Signed dip slope |
| z0err_vld | output | 1 | z0 error valid strobe |
| z0err_out | output | 8 | z0 error code |
| hit_out | output | 10 | Hit map of the presented seed |

## Verification
Seeds are sent with every stereo layer hit, with none hit, with alternating and single-layer patterns, and with only the upper hit-map bits set. The last of these must give the same fit as the empty pattern, which separates correct masking from use of the wrong bits. Curvatures at both ends of the signed range and in the middle pick different bins, which shows whether the bin lookup feeds every bin-keyed table. Back-to-back bursts, isolated seeds and a reload of one table between seeds show latency, ordering, output hold and the effect of table writes.

// File: rtl/zfit_pkg.sv
`timescale 1ns/1ps
package zfit_pkg;
    typedef enum logic [3:0] {
        TS_BIN    = 4'd0,
        TS_SLOPE  = 4'd1,
        TS_RADIUS = 4'd2,
        TS_WGT0   = 4'd3,
        TS_WGT1   = 4'd4,
        TS_T1     = 4'd5,
        TS_T2     = 4'd6,
        TS_T3     = 4'd7,
        TS_DEN    = 4'd8,
        TS_ERR    = 4'd9
    } zfit_tbl_e;
endpackage

// File: rtl/zfit_table.sv
`timescale 1ns/1ps
module zfit_table #(
    parameter int DEPTH = 8,
    parameter int DW    = 16,
    parameter int NRD   = 1,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [DW-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][DW-1:0]  rdata
);
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we && (int'(waddr) < DEPTH)) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '{default: '0};
        else        mem_q <= mem_d;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = (int'(raddr[p]) < DEPTH) ? mem_q[raddr[p]] : '0;
    end

    // R11
    wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (int'(waddr) < DEPTH)) |=> (mem_q[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/zfit_line_solve.sv
`timescale 1ns/1ps
module zfit_line_solve #(
    parameter int HIT_W = 10,
    parameter int TBL_W = 16,
    parameter int ERR_W = 8,
    parameter int SUM_W = 36,
    parameter int MID_W = 40,
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld,
    input  logic [HIT_W-1:0]        in_hit,
    input  logic signed [SUM_W-1:0] sum_a,
    input  logic signed [SUM_W-1:0] sum_b,
    input  logic signed [TBL_W-1:0] t1,
    input  logic signed [TBL_W-1:0] t2,
    input  logic signed [TBL_W-1:0] t3,
    input  logic signed [TBL_W-1:0] den,
    input  logic [ERR_W-1:0]        err,
    output logic                    o_vld,
    output logic [HIT_W-1:0]        o_hit,
    output logic signed [OUT_W-1:0] o_z0,
    output logic signed [OUT_W-1:0] o_dip,
    output logic [ERR_W-1:0]        o_err
);
    localparam int MM_W = SUM_W + TBL_W;
    localparam int DM_W = MID_W + 1 + TBL_W;

    typedef struct {
        logic                    v6;
        logic [HIT_W-1:0]        h6;
        logic signed [MID_W-1:0] pa6, pb6, pc6, pd6;
        logic signed [TBL_W-1:0] den6;
        logic [ERR_W-1:0]        e6;
        logic                    v7;
        logic [HIT_W-1:0]        h7;
        logic signed [OUT_W-1:0] z7, dip7;
        logic [ERR_W-1:0]        e7;
    } solve_t;

    solve_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.v6   = in_vld;
        s_d.h6   = in_hit;
        s_d.pa6  = MID_W'((MM_W'(sum_a) * MM_W'(t1)) >>> 6);
        s_d.pb6  = MID_W'((MM_W'(sum_b) * MM_W'(t2)) >>> 6);
        s_d.pc6  = MID_W'((MM_W'(sum_b) * MM_W'(t3)) >>> 1);
        s_d.pd6  = MID_W'((MM_W'(sum_a) * MM_W'(t2)) >>> 1);
        s_d.den6 = den;
        s_d.e6   = err;
        s_d.v7   = s_q.v6;
        if (s_q.v6) begin
            s_d.h7   = s_q.h6;
            s_d.z7   = OUT_W'(((DM_W'(s_q.pa6) - DM_W'(s_q.pb6)) * DM_W'(s_q.den6)) >>> 16);
            s_d.dip7 = OUT_W'(((DM_W'(s_q.pc6) - DM_W'(s_q.pd6)) * DM_W'(s_q.den6)) >>> 16);
            s_d.e7   = s_q.e6;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{default: '0};
        else        s_q <= s_d;
    end

    assign o_vld = s_q.v7;
    assign o_hit = s_q.h7;
    assign o_z0  = s_q.z7;
    assign o_dip = s_q.dip7;
    assign o_err = s_q.e7;

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !o_vld |-> ($stable(o_z0) && $stable(o_dip) && $stable(o_err) && $stable(o_hit)));

    // R7
    zero_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && sum_a == '0 && sum_b == '0) |=> ##1 (o_vld && o_z0 == '0 && o_dip == '0));
endmodule

// File: rtl/stereo_zfit.sv
`timescale 1ns/1ps
module stereo_zfit
    import zfit_pkg::*;
#(
    parameter int NL     = 6,
    parameter int HIT_W  = 10,
    parameter int PHI_W  = 12,
    parameter int CORR_W = 12,
    parameter int RHO_W  = 8,
    parameter int BIN_W  = 3,
    parameter int TBL_W  = 16,
    parameter int ERR_W  = 8,
    parameter int PC_W   = 18,
    parameter int Z_W    = 18,
    parameter int SUM_W  = 36,
    parameter int MID_W  = 40,
    parameter int OUT_W  = 16,
    localparam int HB_AW  = NL + BIN_W,
    localparam int CFG_AW = (RHO_W > HB_AW) ? RHO_W : HB_AW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 seed_vld,
    input  logic [HIT_W-1:0]     seed_hit,
    input  logic [NL*PHI_W-1:0]  seed_phi,
    input  logic [CORR_W-1:0]    seed_dphi,
    input  logic [CORR_W-1:0]    seed_drho,
    input  logic [RHO_W-1:0]     seed_rho,
    input  logic                 cfg_we,
    input  logic [3:0]           cfg_sel,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [TBL_W-1:0]     cfg_data,
    output logic                 z0_vld,
    output logic [OUT_W-1:0]     z0_out,
    output logic                 dip_vld,
    output logic [OUT_W-1:0]     dip_out,
    output logic                 z0err_vld,
    output logic [ERR_W-1:0]     z0err_out,
    output logic [HIT_W-1:0]     hit_out
);
    localparam int NBIN     = 1 << BIN_W;
    localparam int LB_DEPTH = NL * NBIN;
    localparam int LB_AW    = $clog2(LB_DEPTH);
    localparam int L_AW     = $clog2(NL);
    localparam int SLP_W    = TBL_W + CORR_W;
    localparam int ADD_W    = SLP_W + 2;
    localparam int ZM_W     = TBL_W + PC_W;
    localparam int PM_W     = Z_W + TBL_W;

    typedef struct {
        logic                     v1;
        logic [HIT_W-1:0]         h1;
        logic [BIN_W-1:0]         b1;
        logic signed [PHI_W-1:0]  phi1 [NL];
        logic signed [CORR_W-1:0] dphi1, drho1;
        logic                     v2;
        logic [HIT_W-1:0]         h2;
        logic [BIN_W-1:0]         b2;
        logic signed [PC_W-1:0]   pc2 [NL];
        logic                     v3;
        logic [HIT_W-1:0]         h3;
        logic [BIN_W-1:0]         b3;
        logic signed [Z_W-1:0]    z3 [NL];
        logic                     v4;
        logic [HIT_W-1:0]         h4;
        logic signed [PM_W-1:0]   pa4 [NL];
        logic signed [PM_W-1:0]   pb4 [NL];
        logic signed [TBL_W-1:0]  t1_4, t2_4, t3_4, den4;
        logic [ERR_W-1:0]         e4;
        logic                     v5;
        logic [HIT_W-1:0]         h5;
        logic signed [SUM_W-1:0]  sa5, sb5;
        logic signed [TBL_W-1:0]  t1_5, t2_5, t3_5, den5;
        logic [ERR_W-1:0]         e5;
    } pipe_t;

    pipe_t p_d, p_q;

    // coefficient tables
    logic [0:0][RHO_W-1:0]     bin_ra;
    logic [0:0][BIN_W-1:0]     bin_rd;
    logic [NL-1:0][LB_AW-1:0]  slope_ra, wgt1_ra;
    logic [NL-1:0][TBL_W-1:0]  slope_rd, wgt1_rd, rad_rd, wgt0_rd;
    logic [NL-1:0][L_AW-1:0]   layer_ra;
    logic [0:0][HB_AW-1:0]     hb_ra;
    logic [0:0][NL-1:0]        h_ra;
    logic [0:0][TBL_W-1:0]     t1_rd, t2_rd, t3_rd, den_rd;
    logic [0:0][ERR_W-1:0]     err_rd;

    assign bin_ra[0] = seed_rho;
    assign hb_ra[0]  = {p_q.h3[NL-1:0], p_q.b3};
    assign h_ra[0]   = p_q.h3[NL-1:0];

    for (genvar i = 0; i < NL; i++) begin : g_lay_addr
        assign slope_ra[i] = LB_AW'(i * NBIN) + LB_AW'(p_q.b1);
        assign wgt1_ra[i]  = LB_AW'(i * NBIN) + LB_AW'(p_q.b3);
        assign layer_ra[i] = L_AW'(i);
    end

    zfit_table #(.DEPTH(1 << RHO_W), .DW(BIN_W), .NRD(1), .AW(RHO_W)) u_bin (
        .clk, .rst_n, .we(cfg_we && cfg_sel == TS_BIN), .waddr(cfg_addr[RHO_W-1:0]),
        .wdata(cfg_data[BIN_W-1:0]), .raddr(bin_ra), .rdata(bin_rd));
    zfit_table #(.DEPTH(LB_DEPTH), .DW(TBL_W), .NRD(NL), .AW(LB_AW)) u_slope (
        .clk, .rst_n, .we(cfg_we && cfg_sel == TS_SLOPE), .waddr(cfg_addr[LB_AW-1:0]),
        .wdata(cfg_data), .raddr(slope_ra), .rdata(slope_rd));
    zfit_table #(.DEPTH(NL), .DW(TBL_W), .NRD(NL), .AW(L_AW)) u_radius (
        .clk, .rst_n, .we(cfg_we && cfg_sel == TS_RADIUS), .waddr(cfg_addr[L_AW-1:0]),
        .wdata(cfg_data), .raddr(layer_ra), .rdata(rad_rd));
    zfit_table #(.DEPTH(NL), .DW(TBL_W), .NRD(NL), .AW(L_AW)) u_wgt0 (
        .clk, .rst_n, .we(cfg_we && cfg_sel == TS_WGT0), .waddr(cfg_addr[L_AW-1:0]),
        .wdata(cfg_data), .raddr(layer_ra), .rdata(wgt0_rd));
    zfit_table #(.DEPTH(LB_DEPTH), .DW(TBL_W), .NRD(NL), .AW(LB_AW)) u_wgt1 (
        .clk, .rst_n, .we(cfg_we && cfg_sel == TS_WGT1), .waddr(cfg_addr[LB_AW-1:0]),
        .wdata(cfg_data), .raddr(wgt1_ra), .rdata(wgt1_rd));
    zfit_table #(.DEPTH(1 << HB_AW), .DW(TBL_W), .NRD(1), .AW(HB_AW)) u_t1 (
        .clk, .rst_n, .we(cfg_we && cfg_sel == TS_T1), .waddr(cfg_addr[HB_AW-1:0]),
        .wdata(cfg_data), .raddr(hb_ra), .rdata(t1_rd));
    zfit_table #(.DEPTH(1 << HB_AW), .DW(TBL_W), .NRD(1), .AW(HB_AW)) u_t2 (
        .clk, .rst_n, .we(cfg_we && cfg_sel == TS_T2), .waddr(cfg_addr[HB_AW-1:0]),
        .wdata(cfg_data), .raddr(hb_ra), .rdata(t2_rd));
    zfit_table #(.DEPTH(1 << NL), .DW(TBL_W), .NRD(1), .AW(NL)) u_t3 (
        .clk, .rst_n, .we(cfg_we && cfg_sel == TS_T3), .waddr(cfg_addr[NL-1:0]),
        .wdata(cfg_data), .raddr(h_ra), .rdata(t3_rd));
    zfit_table #(.DEPTH(1 << HB_AW), .DW(TBL_W), .NRD(1), .AW(HB_AW)) u_den (
        .clk, .rst_n, .we(cfg_we && cfg_sel == TS_DEN), .waddr(cfg_addr[HB_AW-1:0]),
        .wdata(cfg_data), .raddr(hb_ra), .rdata(den_rd));
    zfit_table #(.DEPTH(1 << HB_AW), .DW(ERR_W), .NRD(1), .AW(HB_AW)) u_err (
        .clk, .rst_n, .we(cfg_we && cfg_sel == TS_ERR), .waddr(cfg_addr[HB_AW-1:0]),
        .wdata(cfg_data[ERR_W-1:0]), .raddr(hb_ra), .rdata(err_rd));

    always_comb begin
        logic signed [SLP_W-1:0] slp;
        logic signed [ZM_W-1:0]  zm;
        logic signed [SUM_W-1:0] acc_a, acc_b;
        p_d = p_q;
        // stage 1: capture seed, bin lookup
        p_d.v1    = seed_vld;
        p_d.h1    = seed_hit;
        p_d.b1    = bin_rd[0];
        p_d.dphi1 = $signed(seed_dphi);
        p_d.drho1 = $signed(seed_drho);
        for (int i = 0; i < NL; i++) p_d.phi1[i] = $signed(seed_phi[i*PHI_W +: PHI_W]);
        // stage 2: angle correction
        p_d.v2 = p_q.v1;
        p_d.h2 = p_q.h1;
        p_d.b2 = p_q.b1;
        for (int i = 0; i < NL; i++) begin
            slp = SLP_W'($signed(slope_rd[i])) * SLP_W'(p_q.drho1);
            p_d.pc2[i] = PC_W'(ADD_W'(p_q.phi1[i]) - ADD_W'(p_q.dphi1) + ADD_W'(slp >>> 6));
        end
        // stage 3: angle to z
        p_d.v3 = p_q.v2;
        p_d.h3 = p_q.h2;
        p_d.b3 = p_q.b2;
        for (int i = 0; i < NL; i++) begin
            zm = ZM_W'($signed(rad_rd[i])) * ZM_W'(p_q.pc2[i]);
            p_d.z3[i] = Z_W'(zm >>> 8);
        end
        // stage 4: weighted terms for present layers, fit-table lookups
        p_d.v4 = p_q.v3;
        p_d.h4 = p_q.h3;
        for (int i = 0; i < NL; i++) begin
            p_d.pa4[i] = p_q.h3[i] ? PM_W'(p_q.z3[i]) * PM_W'($signed(wgt0_rd[i])) : '0;
            p_d.pb4[i] = p_q.h3[i] ? PM_W'(p_q.z3[i]) * PM_W'($signed(wgt1_rd[i])) : '0;
        end
        p_d.t1_4 = $signed(t1_rd[0]);
        p_d.t2_4 = $signed(t2_rd[0]);
        p_d.t3_4 = $signed(t3_rd[0]);
        p_d.den4 = $signed(den_rd[0]);
        p_d.e4   = err_rd[0];
        // stage 5: sums
        acc_a = '0;
        acc_b = '0;
        for (int i = 0; i < NL; i++) begin
            acc_a = acc_a + SUM_W'(p_q.pa4[i]);
            acc_b = acc_b + SUM_W'(p_q.pb4[i]);
        end
        p_d.v5   = p_q.v4;
        p_d.h5   = p_q.h4;
        p_d.sa5  = acc_a;
        p_d.sb5  = acc_b;
        p_d.t1_5 = p_q.t1_4;
        p_d.t2_5 = p_q.t2_4;
        p_d.t3_5 = p_q.t3_4;
        p_d.den5 = p_q.den4;
        p_d.e5   = p_q.e4;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '{default: '0};
        else        p_q <= p_d;
    end

    logic                    sol_vld;
    logic signed [OUT_W-1:0] sol_z0, sol_dip;

    zfit_line_solve #(.HIT_W(HIT_W), .TBL_W(TBL_W), .ERR_W(ERR_W), .SUM_W(SUM_W),
                      .MID_W(MID_W), .OUT_W(OUT_W)) u_solve (
        .clk, .rst_n, .in_vld(p_q.v5), .in_hit(p_q.h5), .sum_a(p_q.sa5), .sum_b(p_q.sb5),
        .t1(p_q.t1_5), .t2(p_q.t2_5), .t3(p_q.t3_5), .den(p_q.den5), .err(p_q.e5),
        .o_vld(sol_vld), .o_hit(hit_out), .o_z0(sol_z0), .o_dip(sol_dip), .o_err(z0err_out));

    assign z0_vld    = sol_vld;
    assign dip_vld   = sol_vld;
    assign z0err_vld = sol_vld;
    assign z0_out    = sol_z0;
    assign dip_out   = sol_dip;

    // cycles since reset, used to keep $past inside the post-reset window
    logic [3:0] age_d, age_q;
    always_comb age_d = (age_q == 4'd8) ? age_q : age_q + 4'd1;
    always_ff @(posedge clk) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    // R1
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 4'd8) |-> (z0_vld == $past(seed_vld, 7)));

    // R2
    hit_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 4'd8 && z0_vld) |-> (hit_out == $past(seed_hit, 7)));
endmodule

// File: tb/stereo_zfit_bench.sv
`timescale 1ns/1ps
module stereo_zfit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seed_vld = 1'b0;
    logic [9:0]  seed_hit = '0;
    logic [71:0] seed_phi = '0;
    logic [11:0] seed_dphi = '0;
    logic [11:0] seed_drho = '0;
    logic [7:0]  seed_rho = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [8:0]  cfg_addr = '0;
    logic [15:0] cfg_data = '0;
    logic        z0_vld, dip_vld, z0err_vld;
    logic [15:0] z0_out, dip_out;
    logic [7:0]  z0err_out;
    logic [9:0]  hit_out;

    stereo_zfit u_stereo_zfit (
        .clk, .rst_n, .seed_vld, .seed_hit, .seed_phi, .seed_dphi, .seed_drho, .seed_rho,
        .cfg_we, .cfg_sel, .cfg_addr, .cfg_data, .z0_vld, .z0_out, .dip_vld, .dip_out,
        .z0err_vld, .z0err_out, .hit_out);

    always #2.5 clk = ~clk;

    typedef struct {
        logic [9:0] hit;
        longint     z0, dip, err;
        int         cyc;
    } exp_t;

    exp_t   sb[$];
    int     cyc = 0, nchk = 0, nfail = 0;
    int     lcg = 12345;
    bit     done = 1'b0, seen = 1'b0;
    longint last_z0, last_dip, last_err;
    logic [9:0] last_hit;

    longint bin_m[256], slope_m[48], rad_m[6], w0_m[6], w1_m[48];
    longint t1_m[512], t2_m[512], t3_m[64], den_m[512], err_m[512];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic longint rnd(input int m);
        lcg = lcg * 1103515245 + 12345;
        return longint'(((lcg >>> 16) & 32'h7fff) % (2 * m + 1)) - longint'(m);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    task automatic wr(input int sel, input int addr, input longint data);
        cfg_we = 1'b1;
        cfg_sel = 4'(sel);
        cfg_addr = 9'(addr);
        cfg_data = 16'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // reference model built from R4..R10
    function automatic exp_t model(input logic [9:0] hit, input longint p[6],
                                   input longint dphi, input longint drho, input int rho);
        exp_t   e;
        longint b, s1, s2, pc, z;
        int     h6, k;
        b = bin_m[rho & 255];                                   // R4
        s1 = 0;
        s2 = 0;
        for (int i = 0; i < 6; i++) begin
            pc = p[i] - dphi + ((slope_m[i*8 + int'(b)] * drho) >>> 6);   // R5
            z = (rad_m[i] * pc) >>> 8;                          // R6
            if (hit[i]) begin                                   // R7
                s1 += z * w0_m[i];
                s2 += z * w1_m[i*8 + int'(b)];
            end
        end
        h6 = int'(hit & 10'h3f);                                // R3
        k = h6 * 8 + int'(b);
        e.z0 = ((((s1 * t1_m[k]) >>> 6) - ((s2 * t2_m[k]) >>> 6)) * den_m[k]) >>> 16;   // R8
        e.dip = ((((s2 * t3_m[h6]) >>> 1) - ((s1 * t2_m[k]) >>> 1)) * den_m[k]) >>> 16; // R9
        e.err = err_m[k];                                       // R10
        e.hit = hit;
        e.cyc = 0;
        return e;
    endfunction

    task automatic send(input logic [9:0] hit, input longint p[6],
                        input longint dphi, input longint drho, input int rho);
        exp_t e;
        e = model(hit, p, dphi, drho, rho);
        e.cyc = cyc + 7;
        sb.push_back(e);
        seed_vld = 1'b1;
        seed_hit = hit;
        for (int i = 0; i < 6; i++) seed_phi[i*12 +: 12] = 12'(p[i]);
        seed_dphi = 12'(dphi);
        seed_drho = 12'(drho);
        seed_rho = 8'(rho);
        @(negedge clk);
        seed_vld = 1'b0;
    endtask

    task automatic send_rand(input logic [9:0] hit, input int rho);
        longint p[6];
        longint dp, dr;
        for (int i = 0; i < 6; i++) p[i] = rnd(200);
        dp = rnd(50);
        dr = rnd(50);
        send(hit, p, dp, dr, rho);
    endtask

    task automatic drain();
        for (int i = 0; i < 10; i++) @(negedge clk);
    endtask

    // monitor: pops the scoreboard as results appear
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (z0_vld) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R1", "unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(cyc == e.cyc, "R1", "result cycle", cyc, e.cyc);
                    chk(dip_vld && z0err_vld, "R1", "strobes together", {dip_vld, z0err_vld}, 3);
                    chk(hit_out == e.hit, "R2", "hit map", hit_out, e.hit);
                    chk(longint'($signed(z0_out)) == e.z0, "R8", "z0", $signed(z0_out), e.z0);
                    chk(longint'($signed(dip_out)) == e.dip, "R9", "dip", $signed(dip_out), e.dip);
                    chk(longint'(z0err_out) == e.err, "R10", "z0 error", z0err_out, e.err);
                end
                seen = 1'b1;
                last_z0 = longint'($signed(z0_out));
                last_dip = longint'($signed(dip_out));
                last_err = longint'(z0err_out);
                last_hit = hit_out;
            end else if (seen) begin
                chk(longint'($signed(z0_out)) == last_z0 && longint'($signed(dip_out)) == last_dip
                    && longint'(z0err_out) == last_err && hit_out == last_hit,
                    "R12", "hold between strobes", $signed(z0_out), last_z0);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 60000 && !done) begin
            nfail++;
            $display("FAIL R1 watchdog: actual %0d expected %0d", cyc, 60000);
            finish_run();
        end
    end

    initial begin
        longint p[6];
        exp_t   ea, eb;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(!z0_vld && !dip_vld && !z0err_vld, "R12", "reset strobes", z0_vld, 0);
        chk(z0_out == '0 && dip_out == '0, "R12", "reset results", $signed(z0_out), 0);
        chk(z0err_out == '0 && hit_out == '0, "R12", "reset err/hit", z0err_out, 0);

        // R11: load every table through the select/address/data port
        for (int a = 0; a < 256; a++) begin bin_m[a] = rnd(3) + 4; wr(0, a, bin_m[a]); end
        for (int a = 0; a < 48; a++)  begin slope_m[a] = rnd(100); wr(1, a, slope_m[a]); end
        for (int a = 0; a < 6; a++)   begin rad_m[a] = rnd(150) + 150; wr(2, a, rad_m[a]); end
        for (int a = 0; a < 6; a++)   begin w0_m[a] = rnd(100); wr(3, a, w0_m[a]); end
        for (int a = 0; a < 48; a++)  begin w1_m[a] = rnd(100); wr(4, a, w1_m[a]); end
        for (int a = 0; a < 512; a++) begin t1_m[a] = rnd(100); wr(5, a, t1_m[a]); end
        for (int a = 0; a < 512; a++) begin t2_m[a] = rnd(100); wr(6, a, t2_m[a]); end
        for (int a = 0; a < 64; a++)  begin t3_m[a] = rnd(100); wr(7, a, t3_m[a]); end
        for (int a = 0; a < 512; a++) begin den_m[a] = rnd(40); wr(8, a, den_m[a]); end
        for (int a = 0; a < 512; a++) begin err_m[a] = rnd(127) + 128; wr(9, a, err_m[a]); end
        drain();

        // R7: all stereo layers, none, alternating, single layers (isolated seeds)
        send_rand(10'h3ff, 5);   drain();
        send_rand(10'h000, 40);  drain();
        send_rand(10'h015, -60); drain();
        send_rand(10'h02a, 90);  drain();
        send_rand(10'h001, 0);   drain();
        send_rand(10'h020, -1);  drain();

        // R3: only upper hit bits set behaves as no layers; same seed with bits 6..9 toggled
        send_rand(10'h3c0, 17); drain();
        for (int i = 0; i < 6; i++) p[i] = rnd(200);
        ea = model(10'h03f, p, 11, -23, 33);
        eb = model(10'h3ff, p, 11, -23, 33);
        chk(ea.z0 == eb.z0 && ea.dip == eb.dip, "R3", "model consistency", ea.z0, eb.z0);
        send(10'h03f, p, 11, -23, 33);
        send(10'h3ff, p, 11, -23, 33);
        send(10'h1bf, p, 11, -23, 33);
        drain();

        // R4: curvature extremes select different bins
        send_rand(10'h3ff, 127);  drain();
        send_rand(10'h3ff, -128); drain();
        send_rand(10'h2d, -100);  drain();

        // R1: back-to-back burst, order preserved
        for (int n = 0; n < 12; n++) send_rand(10'(n * 37 + 5), int'(rnd(128)));
        drain();

        // R5 R6: large corrections on every layer
        for (int i = 0; i < 6; i++) p[i] = (i % 2 == 0) ? 200 : -200;
        send(10'h3ff, p, -50, 50, 77);
        send(10'h3ff, p, 50, -50, 77);
        drain();

        // R11: reload one T3 entry between seeds; the next seed sees it
        for (int i = 0; i < 6; i++) p[i] = rnd(200);
        t3_m[63] = -t3_m[63] + 7;
        wr(7, 63, t3_m[63]);
        send(10'h03f, p, 3, 9, 12);
        drain();

        // gapped traffic
        for (int n = 0; n < 6; n++) begin
            send_rand(10'(n * 91 + 3), int'(rnd(128)));
            @(negedge clk);
            @(negedge clk);
        end
        drain();

        chk(sb.size() == 0, "R1", "all results returned", sb.size(), 0);
        finish_run();
    end
endmodule